// File: doc/BRIEF.md
# Function-Select ALU Slice

This block is a narrow arithmetic/logic slice meant to be tiled into wider datapaths. A four-bit select code, together with a mode bit, chooses one of sixteen bitwise functions or one of sixteen arithmetic functions of two operands. Every arithmetic function is the sum of two derived operand terms plus an optional incoming carry. The terms are computed per bit. Carries are formed by a two-level lookahead and not by a ripple chain.

The slice exports a group generate and a group propagate that do not depend on the carry input. Several slices can therefore be chained in two ways. One way wires each carry output to the next carry input. The other feeds the generate/propagate pairs to an external lookahead unit. An all-ones flag on the result gives an equality test when the slice subtracts with no carry in. Flags from several slices can be ANDed together to compare wider words. An optional output register stage, selected by parameter, retimes all outputs.

Top module: `alu_slice`

## Requirements
- R1: With `logic_mode` high, each result bit depends only on the matching operand bits, with no carries. The function for `fsel` 0 to 15 is, in order: ~A, ~(A|B), ~A&B, all zeros, ~(A&B), ~B, A^B, A&~B, ~A|B, ~(A^B), B, A&B, all ones, A|~B, A|B, A.
- R2: With `logic_mode` low and `carry_in` low, the result is X + Y modulo 2^WIDTH. X is chosen by `fsel[1:0]`: 0 gives A, 1 gives A|B, 2 gives A|~B, 3 gives all ones. Y is chosen by `fsel[3:2]`: 0 gives zero, 1 gives A&~B, 2 gives A&B, 3 gives A.
- R3: In arithmetic mode an asserted `carry_in` adds exactly one to the selected function. In logic mode `carry_in` has no effect on `result`.
- R4: With `fsel` = 0110 in arithmetic mode, the result is A−B−1 without carry in and A−B with carry in. With carry in, `carry_out` is high exactly when A ≥ B, so a low carry out marks a borrow.
- R5: `grp_gen` is high exactly when the unconstrained sum X+Y is at least 2^WIDTH. `grp_prop | grp_gen` is high exactly when X+Y is at least 2^WIDTH−1. Neither output depends on `carry_in` or `logic_mode`.
- R6: `carry_out` equals `grp_gen | (grp_prop & carry_in)`. This is the carry out of X+Y+`carry_in` in both modes.
- R7: `all_ones` is high exactly when every `result` bit is 1. For subtraction with no carry in it signals A == B.
- R8: Four slices chained either by carry ripple or by an external lookahead built from their `grp_prop`/`grp_gen` produce the 16-bit form of R1–R7. The 16-bit form includes the combined group generate and the ANDed equality flag.
- R9: With `REG_OUT` = 1, every output shows the function of the inputs one clock edge after they are applied. An active-low asynchronous reset clears every output to 0. With `REG_OUT` = 0 the outputs are purely combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage and for checking |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| fsel | input | 4 | Function select code |
| logic_mode | input | 1 | 1 = bitwise functions, 0 = arithmetic functions |
| carry_in | input | 1 | Active-high carry in (adds one) |
| result | output | WIDTH | Function result |
| carry_out | output | 1 | Carry out of the slice |
| grp_prop | output | 1 | Group propagate, independent of carry in |
| grp_gen | output | 1 | Group generate, independent of carry in |
| all_ones | output | 1 | High when every result bit is 1 |

## Verification
The main instance uses WIDTH = 4, GRP = 2 and REG_OUT = 1. At this size the complete input space of both modes, all select codes, both carry values and all 256 operand pairs can be swept exhaustively. The sweep is checked through the one-cycle output latency and the reset values. Two further chains of four WIDTH = 4, REG_OUT = 0 slices build 16-bit words, one chain by carry ripple and one by an external lookahead fed from the slices' group terms. Together they expose the cascading meaning of the propagate and generate outputs over random 16-bit operands and the word-wide boundary values.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

   // Selection of the first arithmetic term, coded by fsel[1:0]
   typedef enum logic [1:0] {
      XT_A       = 2'd0,
      XT_A_OR_B  = 2'd1,
      XT_A_OR_NB = 2'd2,
      XT_ONES    = 2'd3
   } xterm_e;

   // Selection of the second arithmetic term, coded by fsel[3:2]
   typedef enum logic [1:0] {
      YT_ZERO     = 2'd0,
      YT_A_AND_NB = 2'd1,
      YT_A_AND_B  = 2'd2,
      YT_A        = 2'd3
   } yterm_e;

   localparam int unsigned FSEL_W  = 4;
   localparam logic [3:0]  SEL_SUB = 4'b0110;

endpackage

// File: rtl/alu_term_gen.sv
module alu_term_gen
   import alu_slice_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0]  op_a,
   input  logic [WIDTH-1:0]  op_b,
   input  logic [FSEL_W-1:0] fsel,
   output logic [WIDTH-1:0]  term_x,
   output logic [WIDTH-1:0]  term_y
);

   xterm_e xs;
   yterm_e ys;

   assign xs = xterm_e'(fsel[1:0]);
   assign ys = yterm_e'(fsel[3:2]);

   // Per-bit term selection; term_y is always a subset of term_x
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         unique case (xs)
            XT_A:       term_x[i] = op_a[i];
            XT_A_OR_B:  term_x[i] = op_a[i] | op_b[i];
            XT_A_OR_NB: term_x[i] = op_a[i] | ~op_b[i];
            default:    term_x[i] = 1'b1;
         endcase
      end

      always_comb begin
         unique case (ys)
            YT_ZERO:     term_y[i] = 1'b0;
            YT_A_AND_NB: term_y[i] = op_a[i] & ~op_b[i];
            YT_A_AND_B:  term_y[i] = op_a[i] & op_b[i];
            default:     term_y[i] = op_a[i];
         endcase
      end
   end

endmodule

// File: rtl/alu_carry_la.sv
module alu_carry_la #(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned GRP   = 2
) (
   input  logic [WIDTH-1:0] prop,
   input  logic [WIDTH-1:0] gen,
   input  logic             cin,
   output logic [WIDTH-1:0] bit_c,
   output logic             cout,
   output logic             grp_p,
   output logic             grp_g
);

   localparam int unsigned NG = WIDTH / GRP;

   logic [NG-1:0] sub_p;
   logic [NG-1:0] sub_g;
   logic [NG:0]   sub_c;

   // First level: propagate/generate of each sub-group, flattened
   for (genvar k = 0; k < NG; k++) begin : g_sub
      logic p_l;
      logic g_l;
      logic [GRP-1:0] c_l;

      always_comb begin
         logic acc;
         acc = 1'b1;
         g_l = 1'b0;
         for (int j = GRP - 1; j >= 0; j--) begin
            g_l = g_l | (gen[k*GRP + j] & acc);
            acc = acc & prop[k*GRP + j];
         end
         p_l = acc;
      end

      // Bit carries inside the sub-group from its own carry in
      always_comb begin
         for (int o = 0; o < GRP; o++) begin
            logic acc2;
            logic v;
            acc2 = 1'b1;
            v    = 1'b0;
            for (int j = o - 1; j >= 0; j--) begin
               v    = v | (gen[k*GRP + j] & acc2);
               acc2 = acc2 & prop[k*GRP + j];
            end
            c_l[o] = v | (acc2 & sub_c[k]);
         end
      end

      assign sub_p[k] = p_l;
      assign sub_g[k] = g_l;
      assign bit_c[k*GRP +: GRP] = c_l;
   end

   // Second level: carry into each sub-group straight from cin
   always_comb begin
      sub_c[0] = cin;
      for (int k = 1; k <= NG; k++) begin
         logic acc;
         logic v;
         acc = 1'b1;
         v   = 1'b0;
         for (int j = k - 1; j >= 0; j--) begin
            v   = v | (sub_g[j] & acc);
            acc = acc & sub_p[j];
         end
         sub_c[k] = v | (acc & cin);
      end
   end

   // Whole-slice terms, free of cin
   always_comb begin
      logic acc;
      acc   = 1'b1;
      grp_g = 1'b0;
      for (int j = NG - 1; j >= 0; j--) begin
         grp_g = grp_g | (sub_g[j] & acc);
         acc   = acc & sub_p[j];
      end
      grp_p = acc;
   end

   assign cout = sub_c[NG];

endmodule

// File: rtl/alu_result.sv
module alu_result #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] term_x,
   input  logic [WIDTH-1:0] term_y,
   input  logic [WIDTH-1:0] bit_c,
   input  logic             logic_mode,
   output logic [WIDTH-1:0] f,
   output logic             eq
);

   logic [WIDTH-1:0] half_sum;
   logic [WIDTH-1:0] c_eff;

   // term_y is contained in term_x, so this is their exclusive OR
   assign half_sum = term_x & ~term_y;
   // Logic mode forces every internal carry high, inverting the half sum
   assign c_eff    = logic_mode ? {WIDTH{1'b1}} : bit_c;
   assign f        = half_sum ^ c_eff;
   assign eq       = &f;

endmodule

// File: rtl/alu_slice.sv
module alu_slice
   import alu_slice_pkg::*;
#(
   parameter int unsigned WIDTH   = 4,
   parameter int unsigned GRP     = 2,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [3:0]       fsel,
   input  logic             logic_mode,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             grp_prop,
   output logic             grp_gen,
   output logic             all_ones
);

   localparam int unsigned NG = (GRP == 0) ? 1 : WIDTH / GRP;

   if (WIDTH < 1) begin : g_bad_width
      $error("alu_slice: WIDTH must be at least 1");
   end
   if (GRP < 1 || GRP > WIDTH) begin : g_bad_grp
      $error("alu_slice: GRP must lie in 1..WIDTH");
   end
   if (NG * GRP != WIDTH) begin : g_bad_split
      $error("alu_slice: WIDTH must be a multiple of GRP");
   end

   logic [WIDTH-1:0] tx, ty, bc, f_c;
   logic             co_c, p_c, g_c, eq_c;

   alu_term_gen #(.WIDTH(WIDTH)) u_terms (
      .op_a   (op_a),
      .op_b   (op_b),
      .fsel   (fsel),
      .term_x (tx),
      .term_y (ty)
   );

   alu_carry_la #(.WIDTH(WIDTH), .GRP(GRP)) u_carry (
      .prop  (tx),
      .gen   (ty),
      .cin   (carry_in),
      .bit_c (bc),
      .cout  (co_c),
      .grp_p (p_c),
      .grp_g (g_c)
   );

   alu_result #(.WIDTH(WIDTH)) u_res (
      .term_x     (tx),
      .term_y     (ty),
      .bit_c      (bc),
      .logic_mode (logic_mode),
      .f          (f_c),
      .eq         (eq_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result    <= '0;
            carry_out <= 1'b0;
            grp_prop  <= 1'b0;
            grp_gen   <= 1'b0;
            all_ones  <= 1'b0;
         end else begin
            result    <= f_c;
            carry_out <= co_c;
            grp_prop  <= p_c;
            grp_gen   <= g_c;
            all_ones  <= eq_c;
         end
      end
   end else begin : g_comb
      assign result    = f_c;
      assign carry_out = co_c;
      assign grp_prop  = p_c;
      assign grp_gen   = g_c;
      assign all_ones  = eq_c;
   end

endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
   parameter int unsigned WIDTH   = 4,
   parameter bit          REG_OUT = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [3:0]       fsel,
   input logic             logic_mode,
   input logic             carry_in,
   input logic [WIDTH-1:0] result,
   input logic             carry_out,
   input logic             grp_prop,
   input logic             grp_gen,
   input logic             all_ones
);

   // Inputs aligned with the outputs they produced
   logic [WIDTH-1:0] ob_a, ob_b;
   logic [3:0]       ob_sel;
   logic             ob_md, ob_ci;

   if (REG_OUT) begin : g_obs_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ob_a   <= '0;
            ob_b   <= '0;
            ob_sel <= '0;
            ob_md  <= 1'b0;
            ob_ci  <= 1'b0;
         end else begin
            ob_a   <= op_a;
            ob_b   <= op_b;
            ob_sel <= fsel;
            ob_md  <= logic_mode;
            ob_ci  <= carry_in;
         end
      end
   end else begin : g_obs_comb
      assign ob_a   = op_a;
      assign ob_b   = op_b;
      assign ob_sel = fsel;
      assign ob_md  = logic_mode;
      assign ob_ci  = carry_in;
   end

   // R1: constant logic functions
   a_r1_logic_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_md && ob_sel == 4'b0011) |-> (result == '0));
   a_r1_logic_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_md && ob_sel == 4'b1100) |-> (&result));
   // R2: select 0 without carry passes A
   a_r2_pass_a: assert property (@(posedge clk) disable iff (!rst_n)
      (!ob_md && ob_sel == 4'b0000 && !ob_ci) |-> (result == ob_a));
   // R4: subtract with carry gives no-borrow carry out
   a_r4_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
      (!ob_md && ob_sel == 4'b0110 && ob_ci) |-> (carry_out == (ob_a >= ob_b)));
   // R6: carry out formed from the exported group terms
   a_r6_cout_from_pg: assert property (@(posedge clk) disable iff (!rst_n)
      carry_out == (grp_gen | (grp_prop & ob_ci)));
   // R7: equality in subtract mode
   a_r7_sub_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (!ob_md && ob_sel == 4'b0110 && !ob_ci) |-> (all_ones == (ob_a == ob_b)));
   // R9: held inputs give held outputs
   a_r9_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(ob_a) && $stable(ob_b) && $stable(ob_sel) && $stable(ob_md)
       && $stable(ob_ci)) |-> $stable(result));

endmodule

bind alu_slice alu_slice_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_a       (op_a),
   .op_b       (op_b),
   .fsel       (fsel),
   .logic_mode (logic_mode),
   .carry_in   (carry_in),
   .result     (result),
   .carry_out  (carry_out),
   .grp_prop   (grp_prop),
   .grp_gen    (grp_gen),
   .all_ones   (all_ones)
);

// File: tb/alu_slice_tb.sv
module alu_slice_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Single registered slice
   logic [3:0] s_a, s_b, s_sel;
   logic       s_md, s_ci;
   logic [3:0] d_f;
   logic       d_co, d_p, d_g, d_eq;

   alu_slice #(.WIDTH(4), .GRP(2), .REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_a(s_a), .op_b(s_b), .fsel(s_sel),
      .logic_mode(s_md), .carry_in(s_ci), .result(d_f), .carry_out(d_co),
      .grp_prop(d_p), .grp_gen(d_g), .all_ones(d_eq));

   // 16-bit chains
   logic [15:0] c_a, c_b;
   logic [3:0]  c_sel;
   logic        c_md, c_ci;
   logic [15:0] rf, lf;
   logic [4:0]  rc, lc;
   logic [3:0]  rp, rg, req, lp, lg, leq;

   assign rc[0] = c_ci;
   for (genvar k = 0; k < 4; k++) begin : g_chain
      alu_slice #(.WIDTH(4), .GRP(2), .REG_OUT(1'b0)) u_rip (
         .clk(clk), .rst_n(rst_n), .op_a(c_a[4*k +: 4]), .op_b(c_b[4*k +: 4]),
         .fsel(c_sel), .logic_mode(c_md), .carry_in(rc[k]), .result(rf[4*k +: 4]),
         .carry_out(rc[k+1]), .grp_prop(rp[k]), .grp_gen(rg[k]), .all_ones(req[k]));
      logic unused_co;
      alu_slice #(.WIDTH(4), .GRP(2), .REG_OUT(1'b0)) u_la (
         .clk(clk), .rst_n(rst_n), .op_a(c_a[4*k +: 4]), .op_b(c_b[4*k +: 4]),
         .fsel(c_sel), .logic_mode(c_md), .carry_in(lc[k]), .result(lf[4*k +: 4]),
         .carry_out(unused_co), .grp_prop(lp[k]), .grp_gen(lg[k]), .all_ones(leq[k]));
   end

   // External lookahead unit built from the slices' group terms
   always_comb begin
      lc[0] = c_ci;
      for (int k = 1; k <= 4; k++) begin
         logic acc, v;
         acc = 1'b1;
         v   = 1'b0;
         for (int j = k - 1; j >= 0; j--) begin
            v   = v | (lg[j] & acc);
            acc = acc & lp[j];
         end
         lc[k] = v | (acc & c_ci);
      end
   end

   function automatic logic [1:0] word_pg(input logic [3:0] p, input logic [3:0] g);
      logic acc, v;
      acc = 1'b1;
      v   = 1'b0;
      for (int j = 3; j >= 0; j--) begin
         v   = v | (g[j] & acc);
         acc = acc & p[j];
      end
      return {acc, v};
   endfunction

   // Behavioural reference
   task automatic ref_calc(input int w, input bit md, input int s, input int a,
                           input int b, input bit ci, output int f, output bit co,
                           output bit g, output bit pg);
      int m, nb, sum;
      m  = (1 << w) - 1;
      nb = ~b & m;
      case (s)
         0:  sum = a;
         1:  sum = a | b;
         2:  sum = a | nb;
         3:  sum = m;
         4:  sum = a + (a & nb);
         5:  sum = (a | b) + (a & nb);
         6:  sum = a + nb;
         7:  sum = (a & nb) + m;
         8:  sum = a + (a & b);
         9:  sum = a + b;
         10: sum = (a | nb) + (a & b);
         11: sum = (a & b) + m;
         12: sum = a + a;
         13: sum = (a | b) + a;
         14: sum = (a | nb) + a;
         default: sum = a + m;
      endcase
      g  = (sum >= m + 1);
      pg = (sum >= m);
      co = (sum + int'(ci) >= m + 1);
      if (md) begin
         case (s)
            0:  f = ~a;
            1:  f = ~(a | b);
            2:  f = ~a & b;
            3:  f = 0;
            4:  f = ~(a & b);
            5:  f = ~b;
            6:  f = a ^ b;
            7:  f = a & ~b;
            8:  f = ~a | b;
            9:  f = ~(a ^ b);
            10: f = b;
            11: f = a & b;
            12: f = m;
            13: f = a | ~b;
            14: f = a | b;
            default: f = a;
         endcase
         f = f & m;
      end else begin
         f = (sum + int'(ci)) & m;
      end
   endtask

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Expected-value queues for the registered slice
   int    q_f[$];
   bit    q_co[$], q_g[$], q_pg[$];
   string q_tag[$];

   task automatic drain_one();
      int  ef;
      bit  eco, eg, epg;
      string t;
      if (q_f.size() > 0) begin
         ef = q_f.pop_front(); eco = q_co.pop_front();
         eg = q_g.pop_front(); epg = q_pg.pop_front(); t = q_tag.pop_front();
         check(t, "result", int'(d_f), ef);
         check("R6", "carry_out", int'(d_co), int'(eco));
         check("R5", "grp_gen", int'(d_g), int'(eg));
         check("R5", "grp_prop|grp_gen", int'(d_p | d_g), int'(epg));
         check("R7", "all_ones", int'(d_eq), int'(ef == 15));
      end
   endtask

   task automatic apply(input bit md, input int s, input int a, input int b, input bit ci);
      int f;
      bit co, g, pg;
      s_md = md; s_sel = 4'(s); s_a = 4'(a); s_b = 4'(b); s_ci = ci;
      ref_calc(4, md, s, a, b, ci, f, co, g, pg);
      q_f.push_back(f); q_co.push_back(co); q_g.push_back(g); q_pg.push_back(pg);
      q_tag.push_back(md ? (ci ? "R3" : "R1") : (ci ? "R3" : "R2"));
   endtask

   task automatic chain_check(input string t);
      int f;
      bit co, g, pg;
      logic [1:0] rw, lw;
      #1;
      ref_calc(16, c_md, int'(c_sel), int'(c_a), int'(c_b), c_ci, f, co, g, pg);
      rw = word_pg(rp, rg);
      lw = word_pg(lp, lg);
      check(t, "R8 ripple result", int'(rf), f);
      check(t, "R8 lookahead result", int'(lf), f);
      check("R8", "ripple carry out", int'(rc[4]), int'(co));
      check("R8", "lookahead carry out", int'(lc[4]), int'(co));
      check("R8", "word generate", int'(rw[0]), int'(g));
      check("R8", "word prop|gen", int'(rw[1] | rw[0]), int'(pg));
      check("R8", "lookahead generate", int'(lw[0]), int'(g));
      check("R8", "ANDed all_ones", int'(&req), int'(f == 16'hFFFF));
      check("R8", "ANDed all_ones lookahead", int'(&leq), int'(f == 16'hFFFF));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      s_a = 4'd9; s_b = 4'd6; s_sel = 4'd9; s_md = 1'b0; s_ci = 1'b1;
      c_a = '0; c_b = '0; c_sel = '0; c_md = 1'b0; c_ci = 1'b0;
      repeat (2) @(negedge clk);
      // R9: reset clears every output
      check("R9", "reset result", int'(d_f), 0);
      check("R9", "reset carry_out", int'(d_co), 0);
      check("R9", "reset grp_prop", int'(d_p), 0);
      check("R9", "reset grp_gen", int'(d_g), 0);
      check("R9", "reset all_ones", int'(d_eq), 0);
      rst_n = 1'b1;

      // R1 R2 R3 R5 R6 R7: exhaustive sweep through the output register
      for (int md = 0; md < 2; md++)
         for (int ci = 0; ci < 2; ci++)
            for (int s = 0; s < 16; s++)
               for (int a = 0; a < 16; a++)
                  for (int b = 0; b < 16; b++) begin
                     @(negedge clk);
                     drain_one();
                     apply(bit'(md), s, a, b, bit'(ci));
                  end
      @(negedge clk);
      drain_one();

      // R9: one-cycle latency (last sweep vector left result = 15)
      s_md = 1'b1; s_sel = 4'b0011; s_ci = 1'b0;
      #1 check("R9", "result before edge", int'(d_f), 15);
      @(negedge clk);
      check("R9", "result after edge", int'(d_f), 0);

      // R4: subtraction and borrow
      s_md = 1'b0; s_sel = 4'b0110; s_ci = 1'b1; s_a = 4'd5; s_b = 4'd3;
      @(negedge clk);
      check("R4", "5-3 result", int'(d_f), 2);
      check("R4", "5-3 carry_out", int'(d_co), 1);
      s_a = 4'd3; s_b = 4'd5;
      @(negedge clk);
      check("R4", "3-5 result", int'(d_f), 14);
      check("R4", "3-5 carry_out", int'(d_co), 0);
      s_ci = 1'b0; s_a = 4'd5; s_b = 4'd3;
      @(negedge clk);
      check("R4", "5-3-1 result", int'(d_f), 1);

      // R7: equality in subtract mode
      s_a = 4'd9; s_b = 4'd9;
      @(negedge clk);
      check("R7", "equal all_ones", int'(d_eq), 1);
      s_b = 4'd8;
      @(negedge clk);
      check("R7", "unequal all_ones", int'(d_eq), 0);

      // R3: carry in ignored in logic mode
      s_md = 1'b1; s_sel = 4'b0110; s_a = 4'd5; s_b = 4'd3; s_ci = 1'b0;
      @(negedge clk);
      check("R3", "logic xor cin0", int'(d_f), 6);
      s_ci = 1'b1;
      @(negedge clk);
      check("R3", "logic xor cin1", int'(d_f), 6);

      // R8: 16-bit chains, word boundaries first
      @(negedge clk);
      c_md = 1'b0; c_sel = 4'b1001; c_a = 16'hFFFF; c_b = 16'h0000; c_ci = 1'b1;
      chain_check("R2");
      c_sel = 4'b0110; c_a = 16'h1234; c_b = 16'h1234; c_ci = 1'b0;
      chain_check("R7");
      c_a = 16'h1233; c_ci = 1'b1;
      chain_check("R4");
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         c_a = 16'($urandom); c_b = 16'($urandom);
         c_sel = 4'($urandom); c_md = 1'($urandom); c_ci = 1'($urandom);
         chain_check(c_md ? "R1" : "R2");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule